// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal valid/ready request bus and an external asynchronous static RAM of 2M bytes. Each accepted request is one single-byte read or write. The block turns it into timed strobes on the memory pins: a 21-bit address, two chip enables of opposite polarity, an active-low write strobe and an active-low output enable. The shared 8-bit data bus is split into an output value, an output-enable and an input value.

Every phase length is a whole number of clock cycles. Each one comes from a nanosecond parameter divided by the clock period, rounded up, with a minimum of one cycle. The phases cover the read access, the write strobe low time, the full write cycle, the bus turnaround after a read, the recovery after leaving low power, and the wait after power-up.

A write ends when the write strobe rises, while both chip enables stay asserted, so the write strobe is always the edge that terminates the write. The low-power input deselects the memory once the controller is idle. The next request wakes the memory again.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low and the memory stays deselected for PU_CYC clock edges. `req_ready` first reads high after the PU_CYC-th rising edge following reset release.
- R2: Select encoding. The memory is selected exactly when `sram_ce1_n`=0 and `sram_ce2`=1, and it is deselected with `sram_ce1_n`=1 and `sram_ce2`=0. It is deselected during the power-up wait and in low power, and selected in every other state.
- R3: Read. For RD_CYC cycles after the handshake edge, `sram_oe_n`=0 and `sram_we_n`=1, and `sram_addr` is held. Data on `sram_dq_i` is sampled at the end of the last of those cycles. `rsp_valid` is then high for exactly one cycle, with that byte on `rsp_rdata`.
- R4: Write. `sram_we_n` is low for WP_CYC cycles while `sram_oe_n`=1. It then rises while both chip enables stay asserted and the address is unchanged. The whole write occupies WC_CYC cycles, where WC_CYC is the larger of the rounded write-cycle time and WP_CYC+1.
- R5: `sram_dq_oe` is high only while `sram_we_n`=0 and `sram_oe_n`=1, and `sram_dq_o` then carries the accepted write byte.
- R6: A write accepted right after a read waits TA_CYC cycles with both strobes high before `sram_we_n` falls, so at least TA_CYC full cycles separate `sram_oe_n` rising from `sram_we_n` falling.
- R7: No turnaround gap is added for write after write, read after write, or read after read. Each such access takes only its own RD_CYC or WC_CYC.
- R8: `req_ready` is high only when the controller is idle and the memory is selected. It is low during every active cycle, so a read is busy for RD_CYC edges and a write for WC_CYC edges (plus TA_CYC after a read).
- R9: With `lowpwr_req` high, the controller idle and no request present, the memory is deselected after the next edge and `req_ready` drops. A read already in progress completes unchanged.
- R10: A request that arrives while the memory is deselected selects it again. `req_ready` stays low for RC_CYC wake cycles, then the request is accepted. A deselected memory stays deselected until a request arrives, even after `lowpwr_req` falls.
- R11: Every phase length equals ceil(ns / CLK_NS), with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DW | Read byte |
| lowpwr_req | input | 1 | Deselect the memory when idle |
| sram_addr | output | AW | Memory address |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_o | output | DW | Data bus value driven by the controller |
| sram_dq_oe | output | 1 | Controller drives the data bus |
| sram_dq_i | input | DW | Data bus value read from the memory |

## Verification
The bench builds the controller with a 10 ns clock, the default read, write-cycle, turnaround and recovery times, a 35 ns write strobe and a 295 ns power-up wait. The two shortened times round up to 4 and 30 cycles, which exercises the ceiling arithmetic. The short power-up wait lets the run get past the start-up phase within a few dozen cycles. With a 2-cycle turnaround and a write cycle that is longer than the strobe, a read followed at once by a write separates the gap from the recovery phase, so a wrong count in either one changes a measured cycle figure.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int CLK_NS  = 10,
  parameter int AW      = 21,
  parameter int DW      = 8,
  parameter int T_RD_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_WC_NS = 55,
  parameter int T_TA_NS = 20,
  parameter int T_RC_NS = 55,
  parameter int T_PU_NS = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          lowpwr_req,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = cyc(T_RD_NS);
  localparam int WP_CYC  = cyc(T_WP_NS);
  localparam int WC_CYC  = mx(cyc(T_WC_NS), WP_CYC + 1);
  localparam int REC_CYC = WC_CYC - WP_CYC;
  localparam int TA_CYC  = cyc(T_TA_NS);
  localparam int RC_CYC  = cyc(T_RC_NS);
  localparam int PU_CYC  = cyc(T_PU_NS);
  localparam int MAXC    = mx(mx(PU_CYC, RD_CYC), mx(mx(WC_CYC, TA_CYC), RC_CYC));
  localparam int CW      = $clog2(MAXC + 1);
  localparam int KW      = $clog2(mx(WP_CYC, TA_CYC) + 2);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_WAKE, S_TA, S_WR, S_REC, S_RD} st_t;

  st_t           st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic          sel, nsel;
  logic          last_rd, nlast;
  logic          accept;
  logic          cnt_done;

  assign req_ready = (st == S_IDLE) && sel;
  assign accept    = req_valid && req_ready;
  assign cnt_done  = (cnt == '0);

  always_comb begin
    nst   = st;
    ncnt  = cnt;
    nsel  = sel;
    nlast = last_rd;
    unique case (st)
      S_PWR:
        if (cnt_done) begin
          nst  = S_IDLE;
          nsel = 1'b1;
        end else ncnt = cnt - 1'b1;
      S_IDLE:
        if (!sel) begin
          if (req_valid) begin
            nst   = S_WAKE;
            nsel  = 1'b1;
            nlast = 1'b0;
            ncnt  = CW'(RC_CYC - 1);
          end
        end else if (req_valid) begin
          if (!req_write) begin
            nst  = S_RD;
            ncnt = CW'(RD_CYC - 1);
          end else if (last_rd) begin
            nst  = S_TA;
            ncnt = CW'(TA_CYC - 1);
          end else begin
            nst  = S_WR;
            ncnt = CW'(WP_CYC - 1);
          end
        end else if (lowpwr_req) nsel = 1'b0;
      S_WAKE:
        if (cnt_done) nst = S_IDLE;
        else ncnt = cnt - 1'b1;
      S_TA:
        if (cnt_done) begin
          nst   = S_WR;
          nlast = 1'b0;
          ncnt  = CW'(WP_CYC - 1);
        end else ncnt = cnt - 1'b1;
      S_WR:
        if (cnt_done) begin
          nst  = S_REC;
          ncnt = CW'(REC_CYC - 1);
        end else ncnt = cnt - 1'b1;
      S_REC:
        if (cnt_done) begin
          nst   = S_IDLE;
          nlast = 1'b0;
        end else ncnt = cnt - 1'b1;
      S_RD:
        if (cnt_done) begin
          nst   = S_IDLE;
          nlast = 1'b1;
        end else ncnt = cnt - 1'b1;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_PWR;
      cnt        <= CW'(PU_CYC - 1);
      sel        <= 1'b0;
      last_rd    <= 1'b0;
      sram_ce1_n <= 1'b1;
      sram_ce2   <= 1'b0;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
    end else begin
      st         <= nst;
      cnt        <= ncnt;
      sel        <= nsel;
      last_rd    <= nlast;
      sram_ce1_n <= !nsel;
      sram_ce2   <= nsel;
      sram_we_n  <= !(nst == S_WR);
      sram_oe_n  <= !(nst == S_RD);
      sram_dq_oe <= (nst == S_WR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr <= '0;
      sram_dq_o <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        sram_addr <= req_addr;
        if (req_write) sram_dq_o <= req_wdata;
      end
      rsp_valid <= (st == S_RD) && cnt_done;
      if ((st == S_RD) && cnt_done) rsp_rdata <= sram_dq_i;
    end
  end

  logic [KW-1:0] we_lo_cnt, oe_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= KW'(TA_CYC);
    end else begin
      if (sram_we_n) we_lo_cnt <= '0;
      else if (we_lo_cnt < KW'(WP_CYC)) we_lo_cnt <= we_lo_cnt + 1'b1;
      if (!sram_oe_n) oe_hi_cnt <= '0;
      else if (oe_hi_cnt < KW'(TA_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_cnt >= KW'(WP_CYC)));
  // R4
  we_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce1_n && sram_ce2 && $stable(sram_addr)));
  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> (oe_hi_cnt >= KW'(TA_CYC)));
  // R3
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));
  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sram_ce1_n && sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe));
  // R9
  lowpwr_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && lowpwr_req && !req_valid) |=> (sram_ce1_n && !sram_ce2 && !req_ready));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PU_EXP = 30;
  localparam int WP_EXP = 4;
  localparam int WC_EXP = 6;
  localparam int RD_EXP = 6;
  localparam int TA_EXP = 2;
  localparam int RC_EXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, lowpwr_req = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0] rsp_rdata, sram_dq_o, sram_dq_i;
  logic [20:0] sram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_PERIOD), .T_WP_NS(35), .T_PU_NS(295)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lowpwr_req(lowpwr_req),
    .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i));

  logic [7:0] mem [64];
  assign sram_dq_i = (!sram_ce1_n && sram_ce2 && !sram_oe_n) ? mem[sram_addr[5:0]] : 8'h00;

  int n_chk = 0, n_fail = 0;
  int oe_run = 0, last_oe_run = 0, we_run = 0, last_we_run = 0;
  int oe_gap = 100, last_gap = 0;
  logic prev_we = 1'b1, wr_bad = 1'b0, drive_bad = 1'b0, ce_at_end = 1'b0;
  logic [7:0] wr_cap = '0, last_wr_data = '0;
  logic [20:0] wr_at = '0, last_wr_addr = '0;

  initial for (int i = 0; i < 64; i++) mem[i] = 8'h00;

  always @(negedge clk) if (rst_n) begin
    if (!sram_oe_n) oe_run++;
    else if (oe_run != 0) begin last_oe_run = oe_run; oe_run = 0; end
    if (!sram_we_n) begin
      we_run++;
      wr_cap = sram_dq_o;
      wr_at = sram_addr;
      if (!sram_dq_oe || !sram_oe_n) wr_bad = 1'b1;
    end else if (we_run != 0) begin
      last_we_run = we_run; we_run = 0;
      mem[wr_at[5:0]] = wr_cap;
      last_wr_data = wr_cap; last_wr_addr = wr_at;
      ce_at_end = !sram_ce1_n && sram_ce2;
    end
    if (sram_dq_oe && (sram_we_n || !sram_oe_n)) drive_bad = 1'b1;
    if (!sram_we_n && prev_we) last_gap = oe_gap;
    if (!sram_oe_n) oe_gap = 0; else oe_gap++;
    prev_we = sram_we_n;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [20:0] a, input logic [7:0] d,
                       output int k0, output int k);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    k0 = 0;
    while (!req_ready) begin k0++; @(negedge clk); end
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!req_ready) begin k++; @(negedge clk); end
    #1;
  endtask

  task automatic t_powerup();
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); k = 1; #1;
    check(sram_ce1_n && !sram_ce2, "R2 deselected in power-up", {sram_ce1_n, sram_ce2}, 2'b10);
    check(!req_ready, "R1 ready low in power-up", req_ready, 0);
    while (!req_ready) begin @(negedge clk); k++; end
    #1;
    check(k == PU_EXP, "R1 R11 power-up edges", k, PU_EXP);
    check(!sram_ce1_n && sram_ce2, "R2 selected after power-up", {sram_ce1_n, sram_ce2}, 2'b01);
  endtask

  task automatic t_write(input logic [20:0] a, input logic [7:0] d, input int exp_k, input string tag);
    int k0, k;
    issue(1'b1, a, d, k0, k);
    check(k == exp_k, {tag, " busy cycles"}, k, exp_k);
    check(last_we_run == WP_EXP, "R4 R11 strobe low cycles", last_we_run, WP_EXP);
    check(last_wr_data == d, "R5 driven byte", last_wr_data, d);
    check(last_wr_addr == a, "R4 write address", last_wr_addr, a);
    check(ce_at_end, "R4 chip held after strobe", ce_at_end, 1);
    check(!wr_bad, "R5 driver during strobe", wr_bad, 0);
  endtask

  task automatic t_read(input logic [20:0] a, input logic [7:0] d, input bit pulse, input string tag);
    int k0, k;
    issue(1'b0, a, d, k0, k);
    check(k == RD_EXP, {tag, " busy cycles"}, k, RD_EXP);
    check(last_oe_run == RD_EXP, "R3 output enable cycles", last_oe_run, RD_EXP);
    check(rsp_valid && rsp_rdata == d, "R3 response data", {rsp_valid, rsp_rdata}, {1'b1, d});
    if (pulse) begin
      @(negedge clk); #1;
      check(!rsp_valid, "R3 one-cycle pulse", rsp_valid, 0);
    end
  endtask

  task automatic t_rd_then_wr();
    t_read(21'h1FFFFF, 8'hA5, 1'b0, "R7 read after write");
    t_write(21'h0ABC12, 8'h5A, TA_EXP + WC_EXP, "R6 write after read");
    check(last_gap == TA_EXP + 1, "R6 turnaround gap", last_gap, TA_EXP + 1);
    t_read(21'h0ABC12, 8'h5A, 1'b0, "R7 read after write");
    t_read(21'h000005, 8'h3C, 1'b1, "R7 read after read");
  endtask

  task automatic t_lowpwr();
    int k0, k;
    lowpwr_req = 1'b1;
    @(negedge clk); #1;
    check(sram_ce1_n && !sram_ce2 && !req_ready, "R9 R2 deselect when idle",
          {sram_ce1_n, sram_ce2, req_ready}, 3'b100);
    repeat (3) @(negedge clk);
    #1;
    check(sram_oe_n && sram_we_n && sram_ce1_n, "R9 stays deselected", {sram_oe_n, sram_we_n, sram_ce1_n}, 3'b111);
    issue(1'b0, 21'h1FFFFF, 8'h00, k0, k);
    check(k0 == RC_EXP + 1, "R10 wake wait", k0, RC_EXP + 1);
    check(k == RD_EXP && rsp_valid && rsp_rdata == 8'hA5, "R9 read while low power",
          {k[7:0], rsp_rdata}, {8'(RD_EXP), 8'hA5});
    @(negedge clk); #1;
    check(sram_ce1_n && !sram_ce2, "R9 deselect after read", {sram_ce1_n, sram_ce2}, 2'b10);
    lowpwr_req = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(sram_ce1_n && !req_ready, "R10 no reselect without request", {sram_ce1_n, req_ready}, 2'b10);
    issue(1'b1, 21'h000021, 8'hC3, k0, k);
    check(k0 == RC_EXP + 1, "R10 wake before write", k0, RC_EXP + 1);
    check(k == WC_EXP, "R8 write busy after wake", k, WC_EXP);
    t_read(21'h000021, 8'hC3, 1'b1, "R10 read after wake");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_powerup();
    t_write(21'h1FFFFF, 8'hA5, WC_EXP, "R8 write");
    t_write(21'h000005, 8'h3C, WC_EXP, "R7 write after write");
    t_rd_then_wr();
    t_lowpwr();
    check(!drive_bad, "R5 driver only in write strobe", drive_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule